// File: doc/BRIEF.md
# Strided 2x2 Max-Pooling Engine

This block reduces a feature map of H rows by W columns by C channels to one of H/2 by W/2 by C. It takes the largest of each non-overlapping 2x2 window, channel by channel. The input map sits in a local memory with the channel index varying fastest, then the column, then the row. Elements are signed 8-bit fixed-point values with one sign bit and seven fraction bits, so the compare is a plain two's-complement compare.

A single-cycle `start` pulse launches one pass over the whole map. The engine drives a synchronous read port whose data returns one cycle after the address. It folds the four window values of each output element through a running maximum and presents the results on a valid/ready stream. `done` pulses once when the last pooled element has been taken.

Every read address comes from registers that are stepped by constant amounts: one per channel, twice the channel count per output column, and twice the row size per output row. The logic therefore holds adders only and no runtime multiplier. The map dimensions are parameters; shapes such as 32x32x28 and 16x16x56 are reached by setting them.

Top module: `maxpool_stride_unit`

## Requirements
- R1: While reset is asserted and right after it, `done`, `out_valid` and `mem_rd_en` are all 0.
- R2: Each output value equals the signed maximum of its four window values, with the 8-bit data read as two's complement (8'h80 = -128 is the smallest value, 8'h7F = +127 the largest).
- R3: One pass produces exactly (H/2)*(W/2)*C output elements. They come in order of output row, then output column, with the channel index varying fastest.
- R4: For output element (r, q, c), let b = 2*r*W*C + 2*q*C + c. The engine reads addresses b, b+C, b+W*C and b+W*C+C, in that order, on four consecutive cycles. Read data is expected one cycle after its address.
- R5: While `mem_rd_en` is high, `mem_rd_addr` is never above H*W*C-1.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged on the next cycle. No element is dropped or repeated under any `out_ready` pattern.
- R7: `done` is high for exactly one cycle: the cycle after the clock edge at which the last element of the pass is accepted.
- R8: A `start` pulse that arrives while a pass is in progress (from launch until `done`) has no effect. After the pass ends, no further reads or outputs occur until the next `start`.
- R9: With `out_ready` held high, consecutive elements are accepted exactly 4 cycles apart for the whole pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse for one pass |
| done | output | 1 | One-cycle pulse at the end of a pass |
| mem_rd_en | output | 1 | Read strobe to the feature-map memory |
| mem_rd_addr | output | AW | Read word address |
| mem_rd_data | input | DW | Read data, valid one cycle after the address |
| out_valid | output | 1 | Pooled element available |
| out_ready | input | 1 | Consumer accepts the element |
| out_data | output | DW | Pooled signed element |

## Verification
Timing is fixed by design:
- The bench keeps its own copy of the memory and expects each read address in the cycle it is issued.
- The data for a read is due in the following cycle.
- A pooled value becomes visible two cycles after its fourth read address.
- `done` is due in the cycle after the edge that takes the last element.

All outputs are sampled on the falling edge, and inputs change just after the rising edge, so each comparison looks at settled values for the edge to come. An acceptance seen on one falling edge therefore fixes when `done` is expected. With `out_ready` stuck high, the gap between acceptances is fixed at four cycles. A stall seen on one falling edge must leave the same data on the next.

// File: rtl/pool_pkg.sv
package pool_pkg;

    typedef enum logic {
        GEN_IDLE = 1'b0,
        GEN_RUN  = 1'b1
    } gen_state_e;

    typedef logic [1:0] win_phase_t;

    localparam win_phase_t PH_FIRST = 2'd0;
    localparam win_phase_t PH_LAST  = 2'd3;

endpackage

// File: rtl/pool_addr_gen.sv
module pool_addr_gen
    import pool_pkg::*;
#(
    parameter int H  = 8,
    parameter int W  = 8,
    parameter int C  = 4,
    parameter int AW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             slot_ok,
    output logic             rd_en,
    output logic [AW-1:0]    rd_addr,
    output win_phase_t       rd_phase,
    output logic             elem_start
);
    localparam int OH        = H / 2;
    localparam int OW        = W / 2;
    localparam int CHW       = (C  > 1) ? $clog2(C)  : 1;
    localparam int OCW       = (OW > 1) ? $clog2(OW) : 1;
    localparam int ORW       = (OH > 1) ? $clog2(OH) : 1;
    localparam int ROW_STEP  = 2 * W * C;
    localparam int COL_STEP  = 2 * C;
    localparam int OFF_RIGHT = C;
    localparam int OFF_DOWN  = W * C;
    localparam int OFF_DIAG  = W * C + C;
    localparam int WORDS     = H * W * C;

    typedef struct packed {
        gen_state_e       state;
        win_phase_t       phase;
        logic [AW-1:0]    elem_ptr;
        logic [AW-1:0]    col_base;
        logic [AW-1:0]    row_base;
        logic [CHW-1:0]   ch;
        logic [OCW-1:0]   ocol;
        logic [ORW-1:0]   orow;
    } gen_t;

    gen_t gen_q, gen_d;
    logic issue;
    logic [AW-1:0] offset;

    always_comb begin
        gen_d = gen_q;
        issue = (gen_q.state == GEN_RUN) && ((gen_q.phase != PH_FIRST) || slot_ok);

        case (gen_q.phase)
            2'd0:    offset = '0;
            2'd1:    offset = AW'(OFF_RIGHT);
            2'd2:    offset = AW'(OFF_DOWN);
            default: offset = AW'(OFF_DIAG);
        endcase

        if (gen_q.state == GEN_IDLE) begin
            if (launch) begin
                gen_d          = '0;
                gen_d.state    = GEN_RUN;
            end
        end else if (issue) begin
            gen_d.phase = gen_q.phase + 2'd1;
            if (gen_q.phase == PH_LAST) begin
                if (gen_q.ch == CHW'(C - 1)) begin
                    gen_d.ch = '0;
                    if (gen_q.ocol == OCW'(OW - 1)) begin
                        gen_d.ocol = '0;
                        if (gen_q.orow == ORW'(OH - 1)) begin
                            gen_d.state = GEN_IDLE;
                        end else begin
                            gen_d.orow     = gen_q.orow + 1'b1;
                            gen_d.row_base = gen_q.row_base + AW'(ROW_STEP);
                            gen_d.col_base = gen_q.row_base + AW'(ROW_STEP);
                            gen_d.elem_ptr = gen_q.row_base + AW'(ROW_STEP);
                        end
                    end else begin
                        gen_d.ocol     = gen_q.ocol + 1'b1;
                        gen_d.col_base = gen_q.col_base + AW'(COL_STEP);
                        gen_d.elem_ptr = gen_q.col_base + AW'(COL_STEP);
                    end
                end else begin
                    gen_d.ch       = gen_q.ch + 1'b1;
                    gen_d.elem_ptr = gen_q.elem_ptr + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign rd_en      = issue;
    assign rd_addr    = gen_q.elem_ptr + offset;
    assign rd_phase   = gen_q.phase;
    assign elem_start = issue && (gen_q.phase == PH_FIRST);

    // R5: reads stay inside the map
    assert_addr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> ({1'b0, rd_addr} < (AW+1)'(WORDS)));

    // R4: the four window reads come on consecutive cycles
    assert_burst_of_four_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_phase != PH_LAST) |=> (rd_en && rd_phase == $past(rd_phase) + 2'd1));

endmodule

// File: rtl/pool_max_reduce.sv
module pool_max_reduce
    import pool_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  win_phase_t           rd_phase,
    input  logic signed [DW-1:0] rd_data,
    output logic                 res_valid,
    output logic signed [DW-1:0] res_data
);
    typedef struct packed {
        logic              tag_v;
        win_phase_t        tag_ph;
        logic [DW-1:0]     acc;
    } red_t;

    red_t red_q, red_d;
    logic signed [DW-1:0] acc_s;
    logic signed [DW-1:0] cand;

    always_comb begin
        red_d  = red_q;
        acc_s  = red_q.acc;
        if (red_q.tag_ph == PH_FIRST) cand = rd_data;
        else                          cand = (rd_data > acc_s) ? rd_data : acc_s;
        if (red_q.tag_v) red_d.acc = cand;
        red_d.tag_v  = rd_en;
        red_d.tag_ph = rd_phase;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) red_q <= '0;
        else        red_q <= red_d;
    end

    assign res_valid = red_q.tag_v && (red_q.tag_ph == PH_LAST);
    assign res_data  = cand;

    // R2: a finished maximum is never below the window's third value
    assert_not_below_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_data >= $signed($past(rd_data))));

endmodule

// File: rtl/pool_out_fifo.sv
module pool_out_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] slot;
        logic [PW-1:0]            wr_ptr;
        logic [PW-1:0]            rd_ptr;
        logic [CW-1:0]            count;
    } fifo_t;

    fifo_t f_q, f_d;
    logic pop;

    always_comb begin
        f_d = f_q;
        pop = out_valid && out_ready;
        if (push) begin
            f_d.slot[f_q.wr_ptr] = push_data;
            f_d.wr_ptr = (f_q.wr_ptr == PW'(DEPTH - 1)) ? '0 : f_q.wr_ptr + 1'b1;
        end
        if (pop) begin
            f_d.rd_ptr = (f_q.rd_ptr == PW'(DEPTH - 1)) ? '0 : f_q.rd_ptr + 1'b1;
        end
        f_d.count = f_q.count + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign out_valid = (f_q.count != '0);
    assign out_data  = f_q.slot[f_q.rd_ptr];

    // R6: credits must keep the buffer from overflowing
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (f_q.count < CW'(DEPTH) || pop));

endmodule

// File: rtl/maxpool_stride_unit.sv
module maxpool_stride_unit
    import pool_pkg::*;
#(
    parameter int H         = 8,
    parameter int W         = 8,
    parameter int C         = 4,
    parameter int DW        = 8,
    parameter int AW        = $clog2(H * W * C),
    parameter int OUT_DEPTH = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    output logic                 done,
    output logic                 mem_rd_en,
    output logic [AW-1:0]        mem_rd_addr,
    input  logic signed [DW-1:0] mem_rd_data,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic signed [DW-1:0] out_data
);
    localparam int TOTAL_OUT = (H / 2) * (W / 2) * C;
    localparam int OCW       = $clog2(TOTAL_OUT + 1);
    localparam int CRW       = $clog2(OUT_DEPTH + 1);

    typedef struct packed {
        logic           active;
        logic [CRW-1:0] credit;
        logic [OCW-1:0] taken;
        logic           done;
    } ctl_t;

    ctl_t ctl_q, ctl_d;
    logic launch, slot_ok, elem_start, pop;
    win_phase_t rd_phase;
    logic res_valid;
    logic signed [DW-1:0] res_data;
    logic [DW-1:0] fifo_out;

    always_comb begin
        ctl_d      = ctl_q;
        launch     = start && !ctl_q.active;
        pop        = out_valid && out_ready;
        slot_ok    = (ctl_q.credit < CRW'(OUT_DEPTH));
        ctl_d.done = 1'b0;
        if (launch) ctl_d.active = 1'b1;
        ctl_d.credit = ctl_q.credit + CRW'(elem_start) - CRW'(pop);
        if (pop) begin
            if (ctl_q.taken == OCW'(TOTAL_OUT - 1)) begin
                ctl_d.taken  = '0;
                ctl_d.done   = 1'b1;
                ctl_d.active = 1'b0;
            end else begin
                ctl_d.taken = ctl_q.taken + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign done = ctl_q.done;

    pool_addr_gen #(.H(H), .W(W), .C(C), .AW(AW)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .slot_ok    (slot_ok),
        .rd_en      (mem_rd_en),
        .rd_addr    (mem_rd_addr),
        .rd_phase   (rd_phase),
        .elem_start (elem_start)
    );

    pool_max_reduce #(.DW(DW)) u_reduce (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (mem_rd_en),
        .rd_phase  (rd_phase),
        .rd_data   (mem_rd_data),
        .res_valid (res_valid),
        .res_data  (res_data)
    );

    pool_out_fifo #(.DW(DW), .DEPTH(OUT_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (res_valid),
        .push_data (res_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (fifo_out)
    );

    assign out_data = fifo_out;

    // R6: a stalled element holds its value
    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R7: done never lasts two cycles
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: outstanding elements never exceed buffer room
    assert_credit_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.credit <= CRW'(OUT_DEPTH));

endmodule

// File: tb/maxpool_stride_unit_bench.sv
`timescale 1ns/1ps
module maxpool_stride_unit_bench;
    localparam int H = 8, W = 8, C = 4, DW = 8;
    localparam int AW = $clog2(H * W * C);
    localparam int WORDS = H * W * C;
    localparam int TOTAL_OUT = (H / 2) * (W / 2) * C;

    logic clk = 0, rst_n = 0, start = 0, out_ready = 1;
    logic done, mem_rd_en, out_valid;
    logic [AW-1:0] mem_rd_addr;
    logic signed [DW-1:0] mem_rd_data, out_data;

    logic signed [DW-1:0] mem [0:WORDS-1];
    logic signed [DW-1:0] exp_data_q [$];
    int exp_addr_q [$];

    int checks = 0, fails = 0;
    int cyc = 0, last_hs = -1, dones_seen = 0;
    bit rate_mode = 1, exp_done = 0, prev_stall = 0, finished = 0;
    logic signed [DW-1:0] stall_data;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    maxpool_stride_unit #(.H(H), .W(W), .C(C), .DW(DW)) u_maxpool_stride_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    task automatic load_mem(input int seed);
        for (int i = 0; i < WORDS; i++) mem[i] = DW'((i * 37 + seed * 53) ^ (i >> 2) ^ seed);
        // all-minimum window for element (0,0,0)
        mem[0] = -8'sd128; mem[4] = -8'sd128; mem[32] = -8'sd128; mem[36] = -8'sd128;
        // negative window for (0,0,1): max is -1 at the first read
        mem[1] = -8'sd1; mem[5] = -8'sd128; mem[33] = -8'sd5; mem[37] = -8'sd2;
        // largest value on the last read of (0,0,2)
        mem[38] = 8'sd127;
    endtask

    // driver: expected addresses and pooled values, in R3/R4 order
    task automatic queue_pass();
        for (int r = 0; r < H / 2; r++)
            for (int q = 0; q < W / 2; q++)
                for (int c = 0; c < C; c++) begin
                    int b;
                    logic signed [DW-1:0] m;
                    b = 2 * r * W * C + 2 * q * C + c;
                    exp_addr_q.push_back(b);
                    exp_addr_q.push_back(b + C);
                    exp_addr_q.push_back(b + W * C);
                    exp_addr_q.push_back(b + W * C + C);
                    m = mem[b];
                    if (mem[b + C] > m) m = mem[b + C];
                    if (mem[b + W * C] > m) m = mem[b + W * C];
                    if (mem[b + W * C + C] > m) m = mem[b + W * C + C];
                    exp_data_q.push_back(m);
                end
    endtask

    task automatic pulse_start();
        @(posedge clk); #1 start = 1;
        @(posedge clk); #1 start = 0;
    endtask

    // ready pattern
    initial forever begin
        @(posedge clk); #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = rate_mode ? 1'b1 : (lfsr[0] | lfsr[5]);
    end

    // monitor
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (mem_rd_en) begin
                if (exp_addr_q.size() == 0) check(0, "R4/R8 unexpected read", mem_rd_addr, -1);
                else begin
                    int ea;
                    ea = exp_addr_q.pop_front();
                    check(mem_rd_addr == ea, "R4/R5 read address", mem_rd_addr, ea);
                end
            end
            if (done || exp_done) begin
                check(done == exp_done, "R7 done timing", done, exp_done);
                if (done) dones_seen++;
            end
            exp_done = 0;
            if (prev_stall) begin
                check(out_valid && out_data == stall_data, "R6 stall hold", out_data, stall_data);
            end
            prev_stall = out_valid && !out_ready;
            stall_data = out_data;
            if (out_valid && out_ready) begin
                if (exp_data_q.size() == 0) check(0, "R3/R8 extra output", out_data, 0);
                else begin
                    logic signed [DW-1:0] ed;
                    ed = exp_data_q.pop_front();
                    check(out_data == ed, "R2/R3 pooled value", out_data, ed);
                    if (exp_data_q.size() == 0) exp_done = 1;
                end
                if (rate_mode && last_hs >= 0)
                    check(cyc - last_hs == 4, "R9 element spacing", cyc - last_hs, 4);
                last_hs = cyc;
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(done == 0, "R1 done at reset", done, 0);
        check(out_valid == 0, "R1 out_valid at reset", out_valid, 0);
        check(mem_rd_en == 0, "R1 read strobe at reset", mem_rd_en, 0);
        @(posedge clk); #1 rst_n = 1;
        @(negedge clk);
        check(!done && !out_valid && !mem_rd_en, "R1 idle after reset", {done, out_valid, mem_rd_en}, 0);

        // pass 1: ready always high, extra start mid-pass must be ignored (R8)
        load_mem(1);
        queue_pass();
        rate_mode = 1; last_hs = -1;
        pulse_start();
        repeat (30) @(posedge clk);
        pulse_start();
        while (dones_seen < 1) @(posedge clk);
        repeat (20) begin
            @(negedge clk);
            check(!mem_rd_en && !out_valid, "R8 quiet after pass", {mem_rd_en, out_valid}, 0);
        end
        check(exp_data_q.size() == 0, "R3 element count pass 1", exp_data_q.size(), 0);

        // pass 2: irregular backpressure, new data
        load_mem(7);
        queue_pass();
        rate_mode = 0; last_hs = -1;
        pulse_start();
        while (dones_seen < 2) @(posedge clk);
        repeat (10) @(negedge clk);
        check(exp_data_q.size() == 0, "R3 element count pass 2", exp_data_q.size(), 0);
        check(exp_addr_q.size() == 0, "R4 read count", exp_addr_q.size(), 0);
        check(!done, "R7 done low after pulse", done, 0);
        summary();
    end
endmodule